// File: doc/BRIEF.md
# Expanding-Opcode Instruction Decoder

This block takes one 32-bit fixed-length instruction word per strobe and decodes it with an expanding-opcode scheme. Its opcode field gets longer as the operand count gets smaller. The two top bits of the word give the operand class. Each class below three operands is selected by fixed all-ones prefix bytes, and the byte just below those prefix bytes holds the opcode. Each class has its own legal opcode range.

The decoder reports the operand count and an opcode index that starts from zero within its class. It also splits every operand byte into an addressing mode and a register number, and flags words that break the prefix or opcode rules. All results are registered and appear one clock after the input strobe. A downstream execute stage would use the pair of count and index as a unique instruction identifier.

Top module: `expanding_opcode_decoder`

## Requirements
- R1: `out_count` equals word bits 31:30 with this mapping: 3 for 11, 2 for 10, 1 for 01 and 0 for 00. This holds for illegal words too.
- R2: In the three-operand class, the opcode is byte 3 (bits 31:24). Values 0xC0..0xFB are legal, with index = opcode − 0xC0. Values 0xFC..0xFF are illegal.
- R3: In the two-operand class, byte 3 must be 0xBF. The opcode is byte 2 and 0x00..0x7B is legal, with index = opcode.
- R4: In the one-operand class, bytes 3 and 2 must be 0x7F and 0xFF. The opcode is byte 1 and 0x00..0x95 is legal, with index = opcode.
- R5: In the zero-operand class, bytes 3, 2 and 1 must be 0x3F, 0xFF and 0xFF. The opcode is byte 0 and 0x00..0x7F is legal, with index = opcode.
- R6: A word whose prefix bytes do not equal the values its class requires sets `out_illegal`.
- R7: Operand slot i is taken from byte (count−1−i). Its mode is bits 7:5 of that byte and its register is bits 4:0. Slot i occupies `out_mode[3i+2:3i]` and `out_reg[5i+4:5i]`.
- R8: Slots at or above the operand count read zero.
- R9: When `out_illegal` is 1, `out_index` and all slot fields read zero.
- R10: `out_valid` is `in_valid` delayed by exactly one clock. The data outputs load only when `in_valid` is 1 and hold otherwise.
- R11: When `rst_n` is low at a clock edge, all outputs clear to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Instruction word strobe |
| in_word | input | 32 | Instruction word |
| out_valid | output | 1 | Decoded result valid |
| out_count | output | 2 | Operand count |
| out_index | output | 8 | Opcode index within its class |
| out_mode | output | 9 | Addressing modes, slot 0 in the low bits |
| out_reg | output | 15 | Register numbers, slot 0 in the low bits |
| out_illegal | output | 1 | Word breaks prefix or range rules |

## Verification
The bench targets the edges of every range: 0xC0, 0xFB, 0xFC and 0xFF in the three-operand class, and the last legal opcode and the one after it in each other class. An off-by-one compare would accept a reserved opcode or reject the top legal one. Single-byte prefix corruptions check that a decoder looking only at the class bits raises the illegal flag. Slot ordering and zero fill are tested with distinct operand bytes, so a reversed or shifted slot mapping, or stale high slots, shows up in mode or register values. Hold cycles with a changed word but no strobe catch outputs that load without `in_valid`.

// File: rtl/edc_pkg.sv
// Shared constants for the expanding-opcode decoder.
// Assumes four operand classes, indexed by operand count.
package edc_pkg;
    localparam int WORD_W  = 32;
    localparam int BYTE_W  = 8;
    localparam int MODE_W  = 3;
    localparam int REG_W   = 5;
    localparam int SLOTS   = 3;
    localparam int CLASSES = 4;
    localparam int CNT_W   = $clog2(CLASSES);

    // Prefix check per class: the masked word must equal the value.
    localparam logic [WORD_W-1:0] PFX_MASK [CLASSES] =
        '{32'hFFFF_FF00, 32'hFFFF_0000, 32'hFF00_0000, 32'h0000_0000};
    localparam logic [WORD_W-1:0] PFX_VAL [CLASSES] =
        '{32'h3FFF_FF00, 32'h7FFF_0000, 32'hBF00_0000, 32'h0000_0000};
    // Opcode range per class.
    localparam logic [BYTE_W-1:0] OPC_BASE [CLASSES] = '{8'h00, 8'h00, 8'h00, 8'hC0};
    localparam logic [BYTE_W-1:0] OPC_LAST [CLASSES] = '{8'h7F, 8'h95, 8'h7B, 8'hFB};
endpackage

// File: rtl/edc_class_decode.sv
// Combinational class and opcode decode.
// Assumes the opcode of class c sits in byte c, directly below its prefix bytes.
module edc_class_decode
    import edc_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic [CNT_W-1:0]  count,
    output logic [BYTE_W-1:0] index,
    output logic              illegal
);
    logic [BYTE_W-1:0] opc;
    logic              pfx_ok;
    logic              rng_ok;

    // Pick the class, its opcode byte, and check the prefix and range rules.
    always_comb begin
        count   = word[WORD_W-1 -: CNT_W];
        opc     = word[BYTE_W*count +: BYTE_W];
        pfx_ok  = (word & PFX_MASK[count]) == PFX_VAL[count];
        rng_ok  = (opc >= OPC_BASE[count]) && (opc <= OPC_LAST[count]);
        illegal = !(pfx_ok && rng_ok);
        index   = illegal ? '0 : opc - OPC_BASE[count];
    end
endmodule

// File: rtl/edc_operand_split.sv
// Splits operand bytes into mode/register slots.
// Slot i reads byte (count-1-i). Unused slots, and all slots of an illegal word, are zero.
module edc_operand_split
    import edc_pkg::*;
#(
    parameter int N_SLOTS = SLOTS
) (
    input  logic [WORD_W-1:0]         word,
    input  logic [CNT_W-1:0]          count,
    input  logic                      illegal,
    output logic [N_SLOTS*MODE_W-1:0] modes,
    output logic [N_SLOTS*REG_W-1:0]  regs
);
    for (genvar i = 0; i < N_SLOTS; i++) begin : g_slot
        logic [CNT_W-1:0]  src;
        logic [BYTE_W-1:0] opnd;
        // Select this slot's source byte, or zero it when the slot is unused.
        always_comb begin
            src  = count - CNT_W'(i + 1);
            opnd = (!illegal && (i < int'(count))) ? word[BYTE_W*src +: BYTE_W] : '0;
            modes[i*MODE_W +: MODE_W] = opnd[BYTE_W-1 -: MODE_W];
            regs[i*REG_W +: REG_W]    = opnd[REG_W-1:0];
        end
    end
endmodule

// File: rtl/expanding_opcode_decoder.sv
// Top level: registers the decode of one instruction word per in_valid.
// Assumes a synchronous active-low reset. Outputs hold between strobes.
module expanding_opcode_decoder
    import edc_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [31:0]             in_word,
    output logic                    out_valid,
    output logic [1:0]              out_count,
    output logic [7:0]              out_index,
    output logic [SLOTS*MODE_W-1:0] out_mode,
    output logic [SLOTS*REG_W-1:0]  out_reg,
    output logic                    out_illegal
);
    logic [CNT_W-1:0]          d_count;
    logic [BYTE_W-1:0]         d_index;
    logic                      d_illegal;
    logic [SLOTS*MODE_W-1:0]   d_mode;
    logic [SLOTS*REG_W-1:0]    d_reg;

    edc_class_decode u_class (
        .word(in_word), .count(d_count), .index(d_index), .illegal(d_illegal)
    );

    edc_operand_split #(.N_SLOTS(SLOTS)) u_split (
        .word(in_word), .count(d_count), .illegal(d_illegal),
        .modes(d_mode), .regs(d_reg)
    );

    // Output register stage, loaded on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_count   <= '0;
            out_index   <= '0;
            out_mode    <= '0;
            out_reg     <= '0;
            out_illegal <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_count   <= d_count;
                out_index   <= d_index;
                out_mode    <= d_mode;
                out_reg     <= d_reg;
                out_illegal <= d_illegal;
            end
        end
    end

    // Output valid tracks the strobe with one clock of delay.
    assert_valid_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // Data holds while no strobe arrives.
    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_index) && $stable(out_mode) && $stable(out_reg));
    // An illegal result carries no index and no operands.
    assert_illegal_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> (out_index == '0) && (out_mode == '0) && (out_reg == '0));
    // The index never leaves its class range.
    assert_idx3_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_count == 2'd3) |-> out_index <= 8'h3B);
    assert_idx2_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_count == 2'd2) |-> out_index <= 8'h7B);
    assert_idx1_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_count == 2'd1) |-> out_index <= 8'h95);
    assert_idx0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_count == 2'd0) |-> out_index <= 8'h7F);
    // Slots at or above the operand count are empty.
    for (genvar i = 0; i < SLOTS; i++) begin : g_chk
        assert_unused_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (int'(out_count) <= i) |->
            (out_mode[i*MODE_W +: MODE_W] == '0) && (out_reg[i*REG_W +: REG_W] == '0));
    end
endmodule

// File: tb/expanding_opcode_decoder_tb.sv
// Bench: directed corners plus seeded random words, checked against a bench model.
module expanding_opcode_decoder_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_word = '0;
    logic        out_valid;
    logic [1:0]  out_count;
    logic [7:0]  out_index;
    logic [8:0]  out_mode;
    logic [14:0] out_reg;
    logic        out_illegal;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #5 clk = ~clk;

    expanding_opcode_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .out_valid(out_valid), .out_count(out_count), .out_index(out_index),
        .out_mode(out_mode), .out_reg(out_reg), .out_illegal(out_illegal)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Bench model of the decode rules.
    task automatic model(input logic [31:0] w, output logic [1:0] c, output logic [7:0] ix,
                         output logic il, output logic [8:0] m, output logic [14:0] r);
        logic [7:0] op;
        logic [7:0] b;
        logic ok;
        c = w[31:30];
        m = '0; r = '0;
        case (c)
            2'd3: begin op = w[31:24]; ok = (op <= 8'hFB); ix = op - 8'hC0; end
            2'd2: begin op = w[23:16]; ok = (w[31:24] == 8'hBF) && (op <= 8'h7B); ix = op; end
            2'd1: begin op = w[15:8]; ok = (w[31:16] == 16'h7FFF) && (op <= 8'h95); ix = op; end
            default: begin op = w[7:0]; ok = (w[31:8] == 24'h3FFFFF) && (op <= 8'h7F); ix = op; end
        endcase
        il = !ok;
        if (il) ix = '0;
        else begin
            for (int i = 0; i < int'(c); i++) begin
                b = w[8*(int'(c)-1-i) +: 8];
                m[3*i +: 3] = b[7:5];
                r[5*i +: 5] = b[4:0];
            end
        end
    endtask

    task automatic check(input string req, input logic [31:0] w);
        logic [1:0] c; logic [7:0] ix; logic il; logic [8:0] m; logic [14:0] r;
        model(w, c, ix, il, m, r);
        n_tests++;
        if (!out_valid || out_count !== c || out_index !== ix || out_illegal !== il
            || out_mode !== m || out_reg !== r) begin
            n_fail++;
            $display("FAIL %s word=%h got v=%b c=%0d i=%h il=%b m=%h r=%h exp v=1 c=%0d i=%h il=%b m=%h r=%h",
                     req, w, out_valid, out_count, out_index, out_illegal, out_mode, out_reg,
                     c, ix, il, m, r);
        end
    endtask

    // Drive at negedge, sample at the following negedge (one register stage).
    task automatic apply(input string req, input logic [31:0] w);
        in_word = w; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, w);
    endtask

    initial begin
        logic [31:0] w, held;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        n_tests++;
        if (out_valid !== 1'b0 || out_count !== '0 || out_index !== '0 || out_mode !== '0
            || out_reg !== '0 || out_illegal !== 1'b0) begin
            n_fail++;
            $display("FAIL R11 reset state got v=%b c=%0d i=%h exp all zero", out_valid, out_count, out_index);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R2 range edges
        apply("R2", 32'hC0_A1_42_E3);
        apply("R2", 32'hFB_12_34_56);
        apply("R2", 32'hFC_12_34_56);
        apply("R2", 32'hFF_FF_FF_FF);
        // R3
        apply("R3", 32'hBF_7B_C5_2A);
        apply("R3", 32'hBF_7C_C5_2A);
        apply("R3", 32'hBF_00_FF_01);
        // R4
        apply("R4", 32'h7F_FF_95_B7);
        apply("R4", 32'h7F_FF_96_B7);
        // R5
        apply("R5", 32'h3F_FF_FF_7F);
        apply("R5", 32'h3F_FF_FF_80);
        apply("R5", 32'h3F_FF_FF_00);
        // R6 prefix corruptions; R1 count still reported
        apply("R6", 32'hBE_10_C5_2A);
        apply("R6", 32'h7F_FE_10_B7);
        apply("R6", 32'h7E_FF_10_B7);
        apply("R6", 32'h3F_FF_FE_10);
        apply("R1", 32'h00_00_00_00);
        // R7 slot ordering with distinct bytes
        apply("R7", 32'hC5_E1_62_03);

        // R10 hold: new word without strobe leaves outputs alone
        held = 32'hBF_10_E9_4C;
        apply("R10", held);
        in_word = 32'hC1_FF_FF_FF;
        @(negedge clk);
        n_tests++;
        if (out_valid !== 1'b0) begin
            n_fail++; $display("FAIL R10 valid got %b exp 0", out_valid);
        end
        in_valid = 1'b1; in_valid = 1'b0;
        begin
            logic [1:0] c; logic [7:0] ix; logic il; logic [8:0] m; logic [14:0] r;
            model(held, c, ix, il, m, r);
            n_tests++;
            if (out_index !== ix || out_mode !== m || out_reg !== r || out_count !== c) begin
                n_fail++;
                $display("FAIL R10 hold got i=%h m=%h r=%h exp i=%h m=%h r=%h", out_index, out_mode, out_reg, ix, m, r);
            end
        end

        // Random words, biased toward well-formed prefixes (R1..R9)
        for (int k = 0; k < 2000; k++) begin
            w = $urandom;
            case ($urandom_range(0, 3))
                0: w[31:8]  = 24'h3FFFFF;
                1: w[31:16] = 16'h7FFF;
                2: w[31:24] = 8'hBF;
                default: w[31:30] = 2'b11;
            endcase
            if ($urandom_range(0, 7) == 0) w = $urandom;
            apply("R7/R8/R9 random", w);
        end

        // R11 reset mid-stream
        apply("R2", 32'hC3_12_34_56);
        rst_n = 1'b0;
        @(negedge clk);
        n_tests++;
        if (out_valid !== 1'b0 || out_count !== '0 || out_index !== '0 || out_mode !== '0
            || out_reg !== '0) begin
            n_fail++;
            $display("FAIL R11 reset clear got v=%b c=%0d i=%h exp zeros", out_valid, out_count, out_index);
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule